// File: doc/BRIEF.md
# Data Memory and IO Decoder

This block is the memory stage of a small 16-bit processor. Each cycle the pipeline may present a byte address, a load or store strobe, an access size (one byte or one 16-bit word) and write data. The address is decoded into four regions. The first is an 8 KB on-chip data RAM starting at address zero. The second is a 256-byte constant data ROM placed immediately after the RAM. The third is a window of peripheral registers at the very top of the 16-bit address space. Everything else is an unmapped gap.

The RAM is organised as two byte-wide banks, one holding even addresses and one holding odd addresses. A 16-bit access can therefore start on any byte and still finish in the same number of cycles as an aligned one. Words are little-endian: the byte at the access address is the low byte. Loads hold the pipeline for one extra cycle. Peripheral accesses hold it until the peripheral acknowledges. An access the map does not allow is rejected with a single-cycle fault pulse, which the interrupt logic maps to exception number 2.

Top module: `dmem_io_unit`

## Requirements
- R1: Region map. RAM covers 0x0000–0x1FFF, ROM covers 0x2000–0x20FF, peripherals cover 0xFFF0–0xFFFF, and every other address is an unmapped gap. Peripheral register offset = address[3:0], driven on `per_addr`.
- R2: A valid RAM load raises `mem_busy` in the cycle it is presented. In the next cycle `mem_busy` is low and `mem_rdata` holds the result.
- R3: Words are little-endian. The byte at address A lands in `mem_rdata[7:0]` and the byte at A+1 lands in `mem_rdata[15:8]`. Stores place `mem_wdata` the same way.
- R4: A word load or store at an odd RAM address gives the same little-endian result as an aligned access, with identical timing: a store is absorbed in one cycle with `mem_busy` low, and a load is busy for exactly one cycle.
- R5: A byte load returns the addressed byte zero-extended to 16 bits. A byte store changes only the addressed byte and leaves its neighbour intact.
- R6: The ROM byte at offset k (k = address − 0x2000) is k XOR 0x5A. ROM loads have the same timing as RAM loads.
- R7: An invalid access pulses `mem_fault` in the cycle it is presented, with `mem_busy` low and no peripheral strobe. The invalid cases are:
  - any access to the gap;
  - any store into the ROM;
  - a byte-sized peripheral access;
  - an odd-address peripheral access;
  - a word whose second byte falls outside the region of its first byte.
- R8: An invalid store leaves all RAM contents unchanged.
- R9: A valid peripheral store raises `per_wr` for exactly the request cycle, with `per_addr` and `per_wdata` set. `mem_busy` then stays high until the first cycle in which `per_ack` is high, and drops in that cycle.
- R10: A valid peripheral load raises `per_rd` for the request cycle. It waits for `per_ack` like a store, and presents `per_rdata` on `mem_rdata` in the acknowledge cycle.
- R11: After reset `mem_busy`, `mem_fault`, `per_rd` and `per_wr` are low while no request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_load | input | 1 | Load request, held while busy |
| mem_store | input | 1 | Store request, held while busy |
| mem_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| mem_addr | input | 16 | Byte address |
| mem_wdata | input | 16 | Store data (byte stores use bits 7:0) |
| mem_rdata | output | 16 | Load result, valid in the cycle busy drops |
| mem_busy | output | 1 | Stall request to the pipeline |
| mem_fault | output | 1 | Invalid-access pulse |
| per_rd | output | 1 | Peripheral read strobe |
| per_wr | output | 1 | Peripheral write strobe |
| per_addr | output | 4 | Peripheral register offset |
| per_wdata | output | 16 | Peripheral write data |
| per_rdata | input | 16 | Peripheral read data |
| per_ack | input | 1 | Peripheral completion |

## Verification
The hardest situations to reach are the region edges. Examples are a word starting on the last byte of the RAM, which spills into the ROM, and a word starting on the last ROM byte, which spills into the gap. Both look legal on their first byte alone. The bench first writes a known byte just below the RAM end, then attempts the straddling word store. It then reads the byte back, so that a fault which still wrote a bank is caught at the ports. Odd-address word stores are followed by byte loads of both neighbours, which exposes any mistake in steering bytes between the two banks. Peripheral waits are stretched over several cycles by holding the acknowledge low.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

    typedef enum logic [1:0] {
        REG_RAM = 2'd0,
        REG_ROM = 2'd1,
        REG_PER = 2'd2,
        REG_GAP = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_MEM_RD   = 2'd1,
        ST_PER_WAIT = 2'd2
    } ctl_st_e;

    typedef struct packed {
        ctl_st_e st;
        logic    src_rom;
        logic    byte_only;
        logic    per_load;
    } ctl_s;

endpackage

// File: rtl/dmem_addr_decode.sv
module dmem_addr_decode
    import dmem_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int RAM_BYTES = 8192,
    parameter int ROM_BYTES = 256,
    parameter int PER_BYTES = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              word,
    input  logic              store,
    output region_e           region,
    output logic              fault
);
    localparam int SPACE    = 1 << ADDR_W;
    localparam int ROM_END  = RAM_BYTES + ROM_BYTES;
    localparam int PER_BASE = SPACE - PER_BYTES;
    localparam logic [ADDR_W:0] RAM_LIM = (ADDR_W+1)'(RAM_BYTES);
    localparam logic [ADDR_W:0] ROM_LIM = (ADDR_W+1)'(ROM_END);
    localparam logic [ADDR_W:0] PER_LO  = (ADDR_W+1)'(PER_BASE);

    logic [ADDR_W:0] first_b;
    logic [ADDR_W:0] last_b;

    always_comb begin
        first_b = {1'b0, addr};
        last_b  = first_b + {{ADDR_W{1'b0}}, word};
        if (first_b < RAM_LIM)      region = REG_RAM;
        else if (first_b < ROM_LIM) region = REG_ROM;
        else if (first_b >= PER_LO) region = REG_PER;
        else                        region = REG_GAP;

        unique case (region)
            REG_RAM: fault = (last_b >= RAM_LIM);
            REG_ROM: fault = store || (last_b >= ROM_LIM);
            REG_PER: fault = !word || addr[0];
            default: fault = 1'b1;
        endcase
    end
endmodule

// File: rtl/dmem_byte_banks.sv
module dmem_byte_banks #(
    parameter int RAM_BYTES = 8192
) (
    input  logic                         clk,
    input  logic                         re,
    input  logic                         we,
    input  logic                         word,
    input  logic [$clog2(RAM_BYTES)-1:0] addr,
    input  logic [15:0]                  wdata,
    output logic [15:0]                  rdata
);
    localparam int AW     = $clog2(RAM_BYTES);
    localparam int NWORDS = RAM_BYTES / 2;
    localparam int IW     = AW - 1;

    logic [AW-1:0] addr_inc;
    logic [IW-1:0] lane_idx [2];
    logic          lane_we  [2];
    logic [7:0]    lane_wd  [2];
    logic [7:0]    lane_q   [2];
    logic          swap_d, swap_q;

    // lane 0 holds even bytes, lane 1 holds odd bytes
    always_comb begin
        addr_inc    = addr + AW'(1);
        lane_idx[0] = addr_inc[AW-1:1];
        lane_idx[1] = addr[AW-1:1];
        lane_we[0]  = we && (word || !addr[0]);
        lane_we[1]  = we && (word || addr[0]);
        lane_wd[0]  = addr[0] ? wdata[15:8] : wdata[7:0];
        lane_wd[1]  = addr[0] ? wdata[7:0]  : wdata[15:8];
        swap_d      = re ? addr[0] : swap_q;
    end

    for (genvar b = 0; b < 2; b++) begin : g_lane
        logic [7:0] mem [NWORDS];
        always_ff @(posedge clk) begin
            if (lane_we[b]) mem[lane_idx[b]] <= lane_wd[b];
            if (re)         lane_q[b] <= mem[lane_idx[b]];
        end
    end

    always_ff @(posedge clk) swap_q <= swap_d;

    always_comb begin
        rdata = swap_q ? {lane_q[0], lane_q[1]} : {lane_q[1], lane_q[0]};
    end

    assert_no_rw_clash_R4: assert property (@(posedge clk) !(re && we));
endmodule

// File: rtl/dmem_rom.sv
module dmem_rom #(
    parameter int ROM_BYTES = 256
) (
    input  logic                         clk,
    input  logic                         re,
    input  logic [$clog2(ROM_BYTES)-1:0] off,
    output logic [15:0]                  rdata
);
    localparam int RW = $clog2(ROM_BYTES);

    // Constant content: byte k equals the low eight bits of k XOR 0x5A.
    function automatic logic [7:0] rom_byte(input logic [15:0] k);
        return k[7:0] ^ 8'h5A;
    endfunction

    logic [15:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (re) word_d = {rom_byte(16'(off) + 16'd1), rom_byte(16'(off))};
    end

    always_ff @(posedge clk) word_q <= word_d;

    assign rdata = word_q;

    initial if (RW < 1) $error("rom too small");
endmodule

// File: rtl/dmem_io_unit.sv
module dmem_io_unit
    import dmem_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int RAM_BYTES = 8192,
    parameter int ROM_BYTES = 256,
    parameter int PER_BYTES = 16,
    localparam int PER_AW   = $clog2(PER_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_load,
    input  logic              mem_store,
    input  logic              mem_word,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [15:0]       mem_wdata,
    output logic [15:0]       mem_rdata,
    output logic              mem_busy,
    output logic              mem_fault,
    output logic              per_rd,
    output logic              per_wr,
    output logic [PER_AW-1:0] per_addr,
    output logic [15:0]       per_wdata,
    input  logic [15:0]       per_rdata,
    input  logic              per_ack
);
    localparam int RAM_AW = $clog2(RAM_BYTES);
    localparam int ROM_AW = $clog2(ROM_BYTES);

    region_e     region;
    logic        dec_fault;
    logic        ram_re, ram_we, rom_re;
    logic [15:0] ram_word, rom_word;
    logic [ADDR_W-1:0] rom_off_full;
    ctl_s        ctl_d, ctl_q;

    dmem_addr_decode #(
        .ADDR_W(ADDR_W), .RAM_BYTES(RAM_BYTES),
        .ROM_BYTES(ROM_BYTES), .PER_BYTES(PER_BYTES)
    ) dec_i (
        .addr(mem_addr), .word(mem_word), .store(mem_store),
        .region(region), .fault(dec_fault)
    );

    dmem_byte_banks #(.RAM_BYTES(RAM_BYTES)) banks_i (
        .clk(clk), .re(ram_re), .we(ram_we), .word(mem_word),
        .addr(mem_addr[RAM_AW-1:0]), .wdata(mem_wdata), .rdata(ram_word)
    );

    assign rom_off_full = mem_addr - ADDR_W'(RAM_BYTES);

    dmem_rom #(.ROM_BYTES(ROM_BYTES)) rom_i (
        .clk(clk), .re(rom_re), .off(rom_off_full[ROM_AW-1:0]), .rdata(rom_word)
    );

    assign per_addr  = mem_addr[PER_AW-1:0];
    assign per_wdata = mem_wdata;

    always_comb begin
        logic [15:0] src;
        ctl_d     = ctl_q;
        mem_busy  = 1'b0;
        mem_fault = 1'b0;
        mem_rdata = '0;
        per_rd    = 1'b0;
        per_wr    = 1'b0;
        ram_re    = 1'b0;
        ram_we    = 1'b0;
        rom_re    = 1'b0;
        src       = '0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (mem_load || mem_store) begin
                    if (dec_fault) begin
                        mem_fault = 1'b1;
                    end else begin
                        ctl_d.byte_only = !mem_word;
                        unique case (region)
                            REG_RAM: begin
                                if (mem_load) begin
                                    ram_re        = 1'b1;
                                    mem_busy      = 1'b1;
                                    ctl_d.st      = ST_MEM_RD;
                                    ctl_d.src_rom = 1'b0;
                                end else begin
                                    ram_we = 1'b1;
                                end
                            end
                            REG_ROM: begin
                                rom_re        = 1'b1;
                                mem_busy      = 1'b1;
                                ctl_d.st      = ST_MEM_RD;
                                ctl_d.src_rom = 1'b1;
                            end
                            default: begin
                                mem_busy       = 1'b1;
                                per_rd         = mem_load;
                                per_wr         = !mem_load;
                                ctl_d.per_load = mem_load;
                                ctl_d.st       = ST_PER_WAIT;
                            end
                        endcase
                    end
                end
            end
            ST_MEM_RD: begin
                src       = ctl_q.src_rom ? rom_word : ram_word;
                mem_rdata = ctl_q.byte_only ? {8'h00, src[7:0]} : src;
                ctl_d.st  = ST_IDLE;
            end
            default: begin
                if (per_ack) begin
                    mem_rdata = ctl_q.per_load ? per_rdata : 16'h0000;
                    ctl_d.st  = ST_IDLE;
                end else begin
                    mem_busy = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE, src_rom: 1'b0, byte_only: 1'b0, per_load: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assert_fault_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_fault |-> (!mem_busy && !per_wr && !per_rd));
    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({per_wr, per_rd}));
    assert_load_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_MEM_RD) |-> (!mem_busy && $past(mem_busy)));
    assert_wait_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_PER_WAIT && !per_ack) |-> mem_busy);
    assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (per_rd || per_wr) |=> !(per_rd || per_wr));
    assert_fault_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_fault |-> !ram_we);
endmodule

// File: tb/dmem_io_unit_tb_top.sv
module dmem_io_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_load = 0, mem_store = 0, mem_word = 0;
    logic [15:0] mem_addr = 0, mem_wdata = 0;
    logic [15:0] mem_rdata;
    logic        mem_busy, mem_fault, per_rd, per_wr;
    logic [3:0]  per_addr;
    logic [15:0] per_wdata;
    logic [15:0] per_rdata = 0;
    logic        per_ack = 0;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [8192];

    always #2.5 clk = ~clk;

    dmem_io_unit dut_i (
        .clk(clk), .rst_n(rst_n), .mem_load(mem_load), .mem_store(mem_store),
        .mem_word(mem_word), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_busy(mem_busy), .mem_fault(mem_fault),
        .per_rd(per_rd), .per_wr(per_wr), .per_addr(per_addr),
        .per_wdata(per_wdata), .per_rdata(per_rdata), .per_ack(per_ack)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rom_b(input int k);
        return 8'(k) ^ 8'h5A;
    endfunction

    task automatic idle_inputs();
        mem_load = 0; mem_store = 0; mem_word = 0;
    endtask

    task automatic do_store(input logic [15:0] a, input bit w, input logic [15:0] d, input string req);
        @(negedge clk); mem_addr = a; mem_word = w; mem_wdata = d; mem_store = 1; #1;
        chk(!mem_busy && !mem_fault, req, {mem_busy, mem_fault}, 0);
        if (a < 16'h2000) begin
            model[a] = d[7:0];
            if (w) model[a + 1] = d[15:8];
        end
        @(negedge clk); idle_inputs();
    endtask

    task automatic do_load(input logic [15:0] a, input bit w, input logic [15:0] exp, input string req);
        @(negedge clk); mem_addr = a; mem_word = w; mem_load = 1; #1;
        chk(mem_busy && !mem_fault, req, {mem_busy, mem_fault}, 2);
        @(negedge clk); #1;
        chk(!mem_busy, req, mem_busy, 0);
        chk(mem_rdata == exp, req, mem_rdata, exp);
        idle_inputs();
    endtask

    task automatic do_bad(input logic [15:0] a, input bit w, input bit st, input string req);
        @(negedge clk); mem_addr = a; mem_word = w; mem_store = st; mem_load = !st; mem_wdata = 16'hDEAD; #1;
        chk(mem_fault && !mem_busy && !per_wr && !per_rd, req,
            {mem_fault, mem_busy, per_wr, per_rd}, 4'b1000);
        @(negedge clk); idle_inputs(); #1;
        chk(!mem_fault && !mem_busy, req, {mem_fault, mem_busy}, 0);
    endtask

    function automatic logic [15:0] mword(input int a);
        return {model[a + 1], model[a]};
    endfunction

    task automatic t_reset();
        #1;
        chk(!mem_busy && !mem_fault && !per_rd && !per_wr, "R11",
            {mem_busy, mem_fault, per_rd, per_wr}, 0);
    endtask

    task automatic t_aligned();
        do_store(16'h0040, 1, 16'h1234, "R3 store");
        do_load(16'h0040, 1, 16'h1234, "R2 R3 word load");
        do_load(16'h0040, 0, 16'h0034, "R3 low byte");
        do_load(16'h0041, 0, 16'h0012, "R3 high byte");
        do_store(16'h1FFE, 1, 16'hA55A, "R1 top RAM word");
        do_load(16'h1FFE, 1, 16'hA55A, "R1 top RAM word");
    endtask

    task automatic t_unaligned();
        do_store(16'h0100, 1, 16'h1111, "R4 pre");
        do_store(16'h0102, 1, 16'h2222, "R4 pre");
        do_store(16'h0101, 1, 16'hBEEF, "R4 odd store");
        do_load(16'h0101, 1, 16'hBEEF, "R4 odd load");
        do_load(16'h0100, 1, mword(16'h0100), "R4 lower neighbour");
        do_load(16'h0102, 1, mword(16'h0102), "R4 upper neighbour");
        do_load(16'h0103, 0, 16'h0022, "R4 untouched byte");
    endtask

    task automatic t_byte();
        do_store(16'h0200, 1, 16'h8899, "R5 pre");
        do_store(16'h0201, 0, 16'h77F0, "R5 byte store odd");
        do_load(16'h0200, 1, 16'hF099, "R5 neighbour kept");
        do_store(16'h0200, 0, 16'h0011, "R5 byte store even");
        do_load(16'h0200, 1, 16'hF011, "R5 neighbour kept");
        do_load(16'h0201, 0, 16'h00F0, "R5 zero extend");
    endtask

    task automatic t_rom();
        do_load(16'h2000, 1, {rom_b(1), rom_b(0)}, "R6 rom word");
        do_load(16'h2033, 1, {rom_b(16'h34), rom_b(16'h33)}, "R6 rom odd word");
        do_load(16'h20FF, 0, {8'h00, rom_b(255)}, "R6 R1 last rom byte");
        do_load(16'h20FE, 1, {rom_b(255), rom_b(254)}, "R6 last rom word");
    endtask

    task automatic t_invalid();
        do_bad(16'h3000, 1, 0, "R7 gap load");
        do_bad(16'h2100, 0, 0, "R7 R1 first gap byte");
        do_bad(16'hFFEF, 1, 1, "R7 R1 below window");
        do_bad(16'h2010, 0, 1, "R7 rom store");
        do_load(16'h2010, 0, {8'h00, rom_b(16'h10)}, "R7 rom unchanged");
        do_bad(16'h20FF, 1, 0, "R7 rom word straddle");
        do_bad(16'hFFF9, 1, 0, "R7 periph odd");
        do_bad(16'hFFF8, 0, 1, "R7 periph byte");
        do_store(16'h1FFE, 1, 16'hC3C4, "R8 pre");
        do_bad(16'h1FFF, 1, 1, "R7 R8 ram straddle");
        do_load(16'h1FFE, 1, 16'hC3C4, "R8 ram unchanged");
    endtask

    task automatic t_periph_store();
        @(negedge clk); mem_addr = 16'hFFF8; mem_word = 1; mem_wdata = 16'h4B1D; mem_store = 1; #1;
        chk(per_wr && !per_rd && mem_busy, "R9 strobe", {per_wr, per_rd, mem_busy}, 3'b101);
        chk(per_addr == 4'h8 && per_wdata == 16'h4B1D, "R1 R9 addr data", {per_addr, per_wdata}, {4'h8, 16'h4B1D});
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            chk(mem_busy && !per_wr, "R9 wait", {mem_busy, per_wr}, 2'b10);
        end
        @(negedge clk); per_ack = 1; #1;
        chk(!mem_busy, "R9 ack drop", mem_busy, 0);
        @(negedge clk); per_ack = 0; idle_inputs(); #1;
        chk(!mem_busy && !per_wr, "R9 done", {mem_busy, per_wr}, 0);
    endtask

    task automatic t_periph_load();
        @(negedge clk); mem_addr = 16'hFFFE; mem_word = 1; mem_load = 1; #1;
        chk(per_rd && !per_wr && mem_busy && per_addr == 4'hE, "R10 strobe",
            {per_rd, per_wr, mem_busy, per_addr}, {3'b101, 4'hE});
        @(negedge clk); #1;
        chk(mem_busy && !per_rd, "R10 wait", {mem_busy, per_rd}, 2'b10);
        @(negedge clk); per_ack = 1; per_rdata = 16'h6E5C; #1;
        chk(!mem_busy && mem_rdata == 16'h6E5C, "R10 data", {mem_busy, mem_rdata}, {1'b0, 16'h6E5C});
        @(negedge clk); per_ack = 0; idle_inputs();
        // A RAM load right after still works
        do_load(16'h0040, 1, 16'h1234, "R2 after periph");
    endtask

    initial begin
        for (int i = 0; i < 8192; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_aligned();
        t_unaligned();
        t_byte();
        t_rom();
        t_invalid();
        t_periph_store();
        t_periph_load();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule